// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a two-level translation table held in ordinary memory. A request brings the linear address and two flags: whether the access is a write and whether it comes from user privilege. The walker reads one directory word and, unless that word maps a 4 MB page directly, one table word. It checks the combined user and write rights of both levels. Where needed, it writes the entry back with its accessed and dirty marks set. It then returns the physical address and the read and write rights, or a fault with an error code.

Configuration inputs give the paging enable, the write-protect control, the large-page enable, the table base address and the state of the address-bit-20 gate. The gate clears bit 20 of every table address and of the final frame when it is off. Memory is reached through a single 32-bit word port. Each access is held until the memory acknowledges it, so memory may stall for any number of cycles. Only one walk runs at a time, and the configuration is held stable while a walk is in flight.

Top module: `pt_walker`

## Requirements
- R1: With paging disabled, a request completes with no memory access, the physical address equals the linear address (after the bit-20 gate), read and write are both granted, and there is no fault.
- R2: The directory word is read at {table_base[31:12], linear[31:22], 2'b00}, masked by the bit-20 gate.
- R3: A directory word whose present bit (bit 0) is clear ends the walk with a not-present fault and no further memory access.
- R4: When the directory word has its page-size bit (bit 7) set and large pages are enabled, no table word is read and the address is {directory[31:22], linear[21:0]}. When large pages are disabled, bit 7 is ignored and the directory word points to a table.
- R5: The table word is read at {directory[31:12], linear[21:12], 2'b00}, masked by the bit-20 gate. A table word whose present bit is clear gives a not-present fault. A successful small-page address is {table[31:12] gated, linear[11:0]}.
- R6: The effective user right (bit 2) and write right (bit 1) are the AND of both levels. A user access faults without the user right, and a user write faults without the write right.
- R7: A supervisor write to a page without the write right faults only when write protect is on.
- R8: On success the leaf word gets its accessed bit (bit 5) set, and on a write also its dirty bit (bit 6). It is written back only if a bit changed. A directory word that points to a table is written back only to set its accessed bit, and only if that bit was clear.
- R9: The 3-bit error code is {user, write, protection}, where protection is 1 for a rights fault and 0 for not-present. On a fault the read and write rights are 0. On success the error code is 0 and the read right is 1.
- R10: The write right is returned only if the leaf is dirty after the update, and then only if the combined write right is set, or for supervisor access when write protect is off.
- R11: With the bit-20 gate off, bit 20 is cleared in every table address and in the returned frame.
- R12: req_ready is high only when idle, done is a one-cycle pulse, and a memory request keeps its address and direction until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is user privilege |
| cfg_paging | input | 1 | Paging enable |
| cfg_wp | input | 1 | Supervisor write protect |
| cfg_large | input | 1 | 4 MB page enable |
| cfg_base | input | 32 | Directory base address |
| cfg_gate | input | 1 | Address bit 20 gate state |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| done | output | 1 | Result valid pulse |
| rsp_paddr | output | 32 | Physical address |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| rsp_fault | output | 1 | Walk faulted |
| rsp_err | output | 3 | Fault error code |

## Verification
Random walks draw the linear address, the access kind, the control bits, the gate state and the flag bits of both entries. This reaches each outcome: either-level not-present, a rights fault at either level, a large-page hit, and success with or without write-back. These walks also tell apart entries that already carry accessed or dirty marks from those that need them. Directed cases separate paging off from on, and the gate on from off at the same address. They also cover page-size set with large pages enabled and disabled, and a supervisor write to a read-only page under both write-protect settings. Every walk is compared on address, rights, error code, read and write counts, and the entry words left in memory. Memory stalls vary at random so that held requests are exercised.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_lin,
  input  logic        req_write,
  input  logic        req_user,
  input  logic        cfg_paging,
  input  logic        cfg_wp,
  input  logic        cfg_large,
  input  logic [31:0] cfg_base,
  input  logic        cfg_gate,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic [31:0] rsp_paddr,
  output logic        rsp_rd,
  output logic        rsp_wr,
  output logic        rsp_fault,
  output logic [2:0]  rsp_err
);

  typedef enum logic [2:0] {IDLE, DIR_RD, DIR_WR, TBL_RD, TBL_WR, FIN} st_t;

  st_t         st;
  logic [31:0] lin;
  logic        wr_q, usr_q, big_q;
  logic [31:0] dir_q, tbl_q;

  logic [31:0] mask, dir_addr, tbl_addr, upd;
  logic        cu, crw, prot, chg, wperm, big;

  assign mask     = {11'h7ff, cfg_gate, 20'hfffff};
  assign dir_addr = {cfg_base[31:12], lin[31:22], 2'b00} & mask;
  assign tbl_addr = {dir_q[31:12], lin[21:12], 2'b00} & mask;

  assign req_ready = (st == IDLE);
  assign done      = (st == FIN);
  assign mem_req   = (st == DIR_RD) || (st == DIR_WR) || (st == TBL_RD) || (st == TBL_WR);
  assign mem_we    = (st == DIR_WR) || (st == TBL_WR);
  assign mem_addr  = ((st == DIR_RD) || (st == DIR_WR)) ? dir_addr : tbl_addr;
  assign mem_wdata = (st == DIR_WR) ? dir_q : tbl_q;

  assign big = mem_rdata[7] & cfg_large;

  always_comb begin
    cu    = mem_rdata[2] & ((st == TBL_RD) ? dir_q[2] : 1'b1);
    crw   = mem_rdata[1] & ((st == TBL_RD) ? dir_q[1] : 1'b1);
    prot  = usr_q ? (!cu || (wr_q && !crw)) : (cfg_wp && wr_q && !crw);
    upd   = mem_rdata | 32'h20 | (wr_q ? 32'h40 : 32'h0);
    chg   = (upd != mem_rdata);
    wperm = upd[6] && (usr_q ? crw : (crw || !cfg_wp));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      lin       <= '0;
      wr_q      <= 1'b0;
      usr_q     <= 1'b0;
      big_q     <= 1'b0;
      dir_q     <= '0;
      tbl_q     <= '0;
      rsp_paddr <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_err   <= '0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          lin   <= req_lin;
          wr_q  <= req_write;
          usr_q <= req_user;
          if (!cfg_paging) begin
            rsp_paddr <= req_lin & mask;
            rsp_rd    <= 1'b1;
            rsp_wr    <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_err   <= '0;
            st        <= FIN;
          end else begin
            st <= DIR_RD;
          end
        end
        DIR_RD: if (mem_ack) begin
          big_q <= big;
          if (!mem_rdata[0] || (big && prot)) begin
            rsp_fault <= 1'b1;
            rsp_rd    <= 1'b0;
            rsp_wr    <= 1'b0;
            rsp_err   <= {usr_q, wr_q, mem_rdata[0]};
            st        <= FIN;
          end else if (big) begin
            rsp_fault <= 1'b0;
            rsp_rd    <= 1'b1;
            rsp_wr    <= wperm;
            rsp_err   <= '0;
            rsp_paddr <= {mem_rdata[31:22], lin[21:0]};
            dir_q     <= upd;
            st        <= chg ? DIR_WR : FIN;
          end else begin
            dir_q <= mem_rdata | 32'h20;
            st    <= mem_rdata[5] ? TBL_RD : DIR_WR;
          end
        end
        DIR_WR: if (mem_ack) st <= big_q ? FIN : TBL_RD;
        TBL_RD: if (mem_ack) begin
          if (!mem_rdata[0] || prot) begin
            rsp_fault <= 1'b1;
            rsp_rd    <= 1'b0;
            rsp_wr    <= 1'b0;
            rsp_err   <= {usr_q, wr_q, mem_rdata[0]};
            st        <= FIN;
          end else begin
            rsp_fault <= 1'b0;
            rsp_rd    <= 1'b1;
            rsp_wr    <= wperm;
            rsp_err   <= '0;
            rsp_paddr <= {mem_rdata[31:12] & mask[31:12], lin[11:0]};
            tbl_q     <= upd;
            st        <= chg ? TBL_WR : FIN;
          end
        end
        TBL_WR: if (mem_ack) st <= FIN;
        default: st <= IDLE;
      endcase
    end
  end

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  // R8
  wb_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[5] && mem_wdata[0]);

  // R9
  ok_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !rsp_fault |-> rsp_rd && (rsp_err == 3'b000));

  // R11
  gate_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !cfg_gate |-> !mem_addr[20]);

endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        req_write = 1'b0, req_user = 1'b0;
  logic        cfg_paging = 1'b0, cfg_wp = 1'b0, cfg_large = 1'b0, cfg_gate = 1'b1;
  logic [31:0] cfg_base = 32'h0001_0000;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [31:0] rsp_paddr;
  logic        rsp_rd, rsp_wr, rsp_fault;
  logic [2:0]  rsp_err;

  int total = 0, bad = 0, cyc = 0;
  int n_rd = 0, n_wr = 0, stall = 0;
  logic [31:0] mem [logic [31:0]];

  always #4 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .req_write(req_write), .req_user(req_user),
    .cfg_paging(cfg_paging), .cfg_wp(cfg_wp), .cfg_large(cfg_large),
    .cfg_base(cfg_base), .cfg_gate(cfg_gate),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .rsp_paddr(rsp_paddr), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
    .rsp_fault(rsp_fault), .rsp_err(rsp_err)
  );

  function automatic logic [31:0] rd32(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (stall == 0) begin
        mem_ack = 1'b1;
        if (mem_we) begin mem[mem_addr] = mem_wdata; n_wr++; end
        else begin mem_rdata = rd32(mem_addr); n_rd++; end
        stall = $urandom % 4;
      end else stall--;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog R12 act=%0d exp<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input string tag, input logic [31:0] lin, input logic w, input logic u);
    logic [31:0] mask, da, ta, pde, pte, upd, dafter, tafter, pa;
    logic rd, wr, flt, cu, crw, prot;
    logic [2:0] err;
    int erd, ewr, guard;
    mask = {11'h7ff, cfg_gate, 20'hfffff};
    da = {cfg_base[31:12], lin[31:22], 2'b00} & mask;
    pde = rd32(da); dafter = pde;
    ta = {pde[31:12], lin[21:12], 2'b00} & mask;
    pte = rd32(ta); tafter = pte;
    pa = 0; rd = 0; wr = 0; flt = 0; err = 0; erd = 0; ewr = 0;
    if (!cfg_paging) begin
      pa = lin & mask; rd = 1; wr = 1;
    end else begin
      erd = 1;
      if (!pde[0]) begin flt = 1; err = {u, w, 1'b0}; end
      else if (pde[7] && cfg_large) begin
        cu = pde[2]; crw = pde[1];
        prot = u ? (!cu || (w && !crw)) : (cfg_wp && w && !crw);
        if (prot) begin flt = 1; err = {u, w, 1'b1}; end
        else begin
          upd = pde | 32'h20 | (w ? 32'h40 : 32'h0);
          if (upd != pde) begin ewr = 1; dafter = upd; end
          pa = {pde[31:22], lin[21:0]}; rd = 1;
          wr = upd[6] && (u ? crw : (crw || !cfg_wp));
        end
      end else begin
        if (!pde[5]) begin ewr = 1; dafter = pde | 32'h20; end
        erd = 2;
        if (!pte[0]) begin flt = 1; err = {u, w, 1'b0}; end
        else begin
          cu = pde[2] & pte[2]; crw = pde[1] & pte[1];
          prot = u ? (!cu || (w && !crw)) : (cfg_wp && w && !crw);
          if (prot) begin flt = 1; err = {u, w, 1'b1}; end
          else begin
            upd = pte | 32'h20 | (w ? 32'h40 : 32'h0);
            if (upd != pte) begin ewr++; tafter = upd; end
            pa = {pte[31:12] & mask[31:12], lin[11:0]}; rd = 1;
            wr = upd[6] && (u ? crw : (crw || !cfg_wp));
          end
        end
      end
    end
    n_rd = 0; n_wr = 0;
    req_lin = lin; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    chk({tag, " R12 done"}, {31'd0, done}, 32'd1);
    chk({tag, " R3 R6 R7 fault"}, {31'd0, rsp_fault}, {31'd0, flt});
    chk({tag, " R9 err"}, {29'd0, rsp_err}, {29'd0, err});
    chk({tag, " R9 R10 rights"}, {30'd0, rsp_rd, rsp_wr}, {30'd0, rd, wr});
    if (!flt) chk({tag, " R4 R5 R11 paddr"}, rsp_paddr, pa);
    chk({tag, " R1 R3 R4 reads"}, n_rd, erd);
    chk({tag, " R8 writes"}, n_wr, ewr);
    if (cfg_paging) begin
      chk({tag, " R2 R8 dir word"}, rd32(da), dafter);
      if (ta != da) chk({tag, " R5 R8 tbl word"}, rd32(ta), tafter);
    end
    @(negedge clk);
    chk({tag, " R12 ready"}, {31'd0, req_ready}, 32'd1);
  endtask

  task automatic setup(input logic [31:0] lin, input logic [31:0] pde, input logic [31:0] pte);
    logic [31:0] mask, da;
    mask = {11'h7ff, cfg_gate, 20'hfffff};
    mem.delete();
    da = {cfg_base[31:12], lin[31:22], 2'b00} & mask;
    mem[da] = pde;
    mem[{pde[31:12], lin[21:12], 2'b00} & mask] = pte;
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk("reset R12 ready", {31'd0, req_ready}, 32'd1);
    chk("reset R12 done", {31'd0, done}, 32'd0);
    chk("reset R12 mem_req", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 paging off
    cfg_paging = 0; cfg_gate = 1; mem.delete();
    walk("R1 off", 32'h1234_5678, 1, 1);
    // R11 gate off, paging off
    cfg_gate = 0;
    walk("R11 off gate", 32'h0017_3456, 0, 0);
    cfg_paging = 1; cfg_gate = 1; cfg_large = 1; cfg_wp = 0;
    // R3 directory not present
    setup(32'h0040_1000, 32'h0050_0006, 32'h0);
    walk("R3 dir np", 32'h0040_1000, 1, 1);
    // R4 large page
    setup(32'h00A5_5123, 32'h00C0_0087, 32'h0);
    walk("R4 large", 32'h00A5_5123, 1, 1);
    // R4 page-size bit ignored when disabled
    cfg_large = 0;
    setup(32'h00A5_5123, 32'h0060_00A7, 32'h0077_7067);
    walk("R4 ps ignored", 32'h00A5_5123, 1, 1);
    // R7 supervisor write read-only
    setup(32'h0080_2000, 32'h0050_0025, 32'h0066_6065);
    walk("R7 wp off", 32'h0080_2000, 1, 0);
    cfg_wp = 1;
    setup(32'h0080_2000, 32'h0050_0025, 32'h0066_6065);
    walk("R7 wp on", 32'h0080_2000, 1, 0);
    // R8 already accessed, read: no write-back
    setup(32'h0123_4567, 32'h0050_0027, 32'h0066_6027);
    walk("R8 no wb", 32'h0123_4567, 0, 1);
    // R11 gate off on table addresses and frame
    cfg_gate = 0;
    setup(32'h0123_4567, 32'h0051_0007, 32'h0070_1007);
    walk("R11 gate paging", 32'h0123_4567, 1, 0);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] lin, pde, pte;
      cfg_paging = ($urandom % 10) != 0;
      cfg_wp = $urandom; cfg_large = $urandom; cfg_gate = $urandom;
      lin = $urandom;
      pde = 32'h0040_0000 | (($urandom % 1024) << 12) | ($urandom & 32'hfe);
      pde[0] = ($urandom % 8) != 0;
      pte = ($urandom & 32'hffff_f0fe);
      pte[0] = ($urandom % 8) != 0;
      setup(lin, pde, pte);
      walk("rand R2 R5 R6 R8 R10", lin, $urandom, $urandom);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule